// File: doc/BRIEF.md
# Serial Transmitter with Break Control

This block sends bytes as asynchronous serial frames on a single output pin. Software or a DMA agent places a byte in the data register. The byte is then passed to the transmitter by lowering an empty flag in the status register. The transmitter copies the byte into a ten-bit shifter and raises the empty flag again, so the next byte can be queued while the current one is still on the line. When a frame's stop bit ends and no byte is waiting, a done flag rises. Software polls this flag before it shuts the transmitter down.

When the transmitter is disabled, a port register takes over the pin. It can hold the pin at a fixed level or release it. A line break is made by setting the port to drive low and then clearing the enable bit. The empty flag, gated by an interrupt-enable bit, forms a request line that a DMA engine can serve. The DMA engine does this with a write strobe that loads the data and clears the flag in one step.

Top module: `serial_tx_break`

## Requirements
- R1: Each frame is a 0 start bit, then 8 data bits with the least significant bit first, then a 1 stop bit. Every bit lasts divisor+1 clock cycles, where the divisor is the register at address 4.
- R2: While the enable bit (address 2, bit 0) is 0, the pin is driven from the port register (address 3). If bit 1 is 1, txOe is 1 and txPin equals bit 0. If bit 1 is 0, txOe is 0 and txPin is 1.
- R3: While the enable bit is 1, txOe is 1 and the shifter owns txPin, whatever the port register holds. Between frames the pin stays at 1.
- R4: Reading the status register (address 1) while its empty bit (bit 0) is 1 arms it. A following status write with bit 0 at 0 then clears the flag and hands the byte over. The flag reads 1 again one cycle later, once the byte is in the shifter.
- R5: A status write of bit 0 at 0 has no effect unless the flag was read as 1 since enable was set and since the last handover. The flag stays 1 and no frame is sent.
- R6: A pulse on dmaWr loads dmaData into the data register. If enabled, it also clears the empty flag, with no status read needed.
- R7: The done bit (status bit 1) clears on a handover. It sets when a stop bit ends and no byte is pending. A byte that is pending when a stop bit ends starts its frame at once, so start bits of back-to-back frames are exactly 10 bit times apart.
- R8: txReq is 1 exactly when the empty flag is 1 and the request-enable bit (address 2, bit 1) is 1.
- R9: With the port set to drive level 0, clearing the enable bit makes the pin hold a continuous low (break).
- R10: While enable is 0, both status flags read 1. After reset the enable bit is 0 and the divisor reads 3. The data register and the control, port and divisor registers read back what was last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (arms the empty flag when address 1 is read) |
| busAddr | input | 3 | Register address: 0 data, 1 status, 2 control, 3 port, 4 divisor |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr (combinational) |
| dmaWr | input | 1 | DMA data write strobe |
| dmaData | input | 8 | DMA write data |
| txPin | output | 1 | Serial line level |
| txOe | output | 1 | Pin output enable |
| txReq | output | 1 | Transmit-empty request |

## Verification
The in-RTL assertions check the following on every cycle:
- a moved byte raises the empty flag again;
- disabling forces both flags high;
- the done flag only rises after a completed frame with nothing pending;
- the empty flag only falls after a DMA write or an armed status write;
- a loaded frame opens with a low start bit;
- the bit counter holds still inside a bit time.

Only the bench's scenarios can show:
- the decoded byte order and the exact bit lengths;
- the ten-bit-time spacing of back-to-back frames;
- that an unarmed clear is ignored;
- the pin handover between the port register and the shifter, including the held break level.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  localparam logic [2:0] ADDR_DATA = 3'd0;
  localparam logic [2:0] ADDR_STAT = 3'd1;
  localparam logic [2:0] ADDR_CTRL = 3'd2;
  localparam logic [2:0] ADDR_PORT = 3'd3;
  localparam logic [2:0] ADDR_DIV  = 3'd4;

  typedef struct packed {
    logic load;   // copy data register into shifter, frame starts
    logic shift;  // advance to next bit
    logic flush;  // abandon frame, line to mark
  } txStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } txState_t;

endpackage

// File: rtl/serial_tx_regs.sv
module serial_tx_regs
  import serial_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [2:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              dmaWr,
  input  logic [DATA_W-1:0] dmaData,
  input  logic              loadStb,
  input  logic              frameDone,
  output logic [DATA_W-1:0] txData,
  output logic              txEn,
  output logic              irqEn,
  output logic              portLevel,
  output logic              portDrive,
  output logic [DIV_W-1:0]  divisor,
  output logic              emptyFlag,
  output logic              endFlag,
  output logic              txReq
);

  logic statArmed;
  logic swClear;
  logic handover;

  // a zero written to the empty bit counts only after it was seen as one
  assign swClear  = busWr && (busAddr == ADDR_STAT) && !busWdata[0] && statArmed;
  assign handover = txEn && (dmaWr || swClear);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txData <= '0;
    end else if (dmaWr) begin
      txData <= dmaData;
    end else if (busWr && busAddr == ADDR_DATA) begin
      txData <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEn      <= 1'b0;
      irqEn     <= 1'b0;
      portLevel <= 1'b0;
      portDrive <= 1'b0;
      divisor   <= DIV_W'(DIV_RESET);
    end else if (busWr) begin
      if (busAddr == ADDR_CTRL) begin
        txEn  <= busWdata[0];
        irqEn <= busWdata[1];
      end
      if (busAddr == ADDR_PORT) begin
        portLevel <= busWdata[0];
        portDrive <= busWdata[1];
      end
      if (busAddr == ADDR_DIV) begin
        divisor <= busWdata[DIV_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      emptyFlag <= 1'b1;
      endFlag   <= 1'b1;
      statArmed <= 1'b0;
    end else if (!txEn) begin
      emptyFlag <= 1'b1;
      endFlag   <= 1'b1;
      statArmed <= 1'b0;
    end else begin
      if (handover) begin
        emptyFlag <= 1'b0;
      end else if (loadStb) begin
        emptyFlag <= 1'b1;
      end
      if (handover) begin
        endFlag <= 1'b0;
      end else if (frameDone && emptyFlag) begin
        endFlag <= 1'b1;
      end
      if (handover) begin
        statArmed <= 1'b0;
      end else if (busRd && busAddr == ADDR_STAT && emptyFlag) begin
        statArmed <= 1'b1;
      end
    end
  end

  assign txReq = emptyFlag && irqEn;

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      ADDR_DATA: busRdata = txData;
      ADDR_STAT: busRdata[1:0] = {endFlag, emptyFlag};
      ADDR_CTRL: busRdata[1:0] = {irqEn, txEn};
      ADDR_PORT: busRdata[1:0] = {portDrive, portLevel};
      ADDR_DIV:  busRdata[DIV_W-1:0] = divisor;
      default:   busRdata = '0;
    endcase
  end

  // R4: a byte taken by the shifter frees the data register
  a_r4_load_refills_empty: assert property (@(posedge clk) disable iff (!rstN)
    loadStb && !handover |=> emptyFlag);

  // R10: disabled transmitter shows both flags set
  a_r10_disabled_flags_set: assert property (@(posedge clk) disable iff (!rstN)
    !txEn |=> emptyFlag && endFlag);

  // R7: done flag rises only after a finished frame with nothing pending
  a_r7_end_after_frame: assert property (@(posedge clk) disable iff (!rstN)
    $rose(endFlag) && $past(txEn) |-> $past(frameDone) && $past(emptyFlag));

  // R5 and R6: empty flag falls only through DMA or an armed clear
  a_r5_clear_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
    $fell(emptyFlag) |-> $past(dmaWr) ||
      $past(statArmed && busWr && busAddr == ADDR_STAT));

endmodule

// File: rtl/serial_tx_ctrl.sv
module serial_tx_ctrl
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txEn,
  input  logic             emptyFlag,
  input  logic [DIV_W-1:0] divisor,
  output txStrobe_t        strobe,
  output logic             frameDone
);

  localparam int FRAME_BITS = DATA_W + 2;
  localparam int CNT_W      = $clog2(FRAME_BITS);

  txState_t         state;
  logic [DIV_W-1:0] baudCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             bitEnd;
  logic             lastBit;
  logic             sending;

  assign sending = (state == ST_SEND);
  assign bitEnd  = (baudCnt >= divisor);
  assign lastBit = (bitCnt == CNT_W'(FRAME_BITS - 1));

  always_comb begin
    strobe       = '0;
    strobe.load  = txEn && !emptyFlag && (!sending || (bitEnd && lastBit));
    strobe.shift = txEn && sending && bitEnd && !lastBit;
    strobe.flush = !txEn && sending;
    frameDone    = txEn && sending && bitEnd && lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      baudCnt <= '0;
      bitCnt  <= '0;
    end else if (!txEn) begin
      state   <= ST_IDLE;
      baudCnt <= '0;
      bitCnt  <= '0;
    end else if (strobe.load) begin
      state   <= ST_SEND;
      baudCnt <= '0;
      bitCnt  <= '0;
    end else if (sending) begin
      if (bitEnd) begin
        baudCnt <= '0;
        if (lastBit) begin
          state <= ST_IDLE;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end else begin
        baudCnt <= baudCnt + 1'b1;
      end
    end
  end

  // R1: the bit index holds for the whole bit time
  a_r1_bit_held: assert property (@(posedge clk) disable iff (!rstN)
    txEn && sending && !bitEnd |=> $stable(bitCnt));

  // R7: a finished frame with nothing queued returns to idle
  a_r7_idle_after_last: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && emptyFlag |=> state == ST_IDLE);

endmodule

// File: rtl/serial_tx_shift.sv
module serial_tx_shift
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] txData,
  input  logic              txEn,
  input  logic              portLevel,
  input  logic              portDrive,
  output logic              txPin,
  output logic              txOe
);

  localparam int FRAME_BITS = DATA_W + 2;

  logic [FRAME_BITS-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '1;
    end else if (strobe.load) begin
      shReg <= {1'b1, txData, 1'b0};
    end else if (strobe.shift) begin
      shReg <= {1'b1, shReg[FRAME_BITS-1:1]};
    end else if (strobe.flush) begin
      shReg <= '1;
    end
  end

  // shifter owns the pin while enabled, port register otherwise
  assign txPin = txEn ? shReg[0] : (portDrive ? portLevel : 1'b1);
  assign txOe  = txEn || portDrive;

  // R1: every loaded frame opens with a low start bit
  a_r1_start_low: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !shReg[0]);

  // R3: an abandoned frame leaves the line at mark
  a_r3_flush_marks: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> &shReg);

endmodule

// File: rtl/serial_tx_break.sv
module serial_tx_break
  import serial_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [2:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              dmaWr,
  input  logic [DATA_W-1:0] dmaData,
  output logic              txPin,
  output logic              txOe,
  output logic              txReq
);

  txStrobe_t        strobe;
  logic             frameDone;
  logic [DATA_W-1:0] txData;
  logic             txEn;
  logic             irqEn;
  logic             portLevel;
  logic             portDrive;
  logic [DIV_W-1:0] divisor;
  logic             emptyFlag;
  logic             endFlag;

  serial_tx_regs #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .DIV_RESET(DIV_RESET)
  ) u_regs (
    .clk(clk), .rstN(rstN),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .dmaWr(dmaWr), .dmaData(dmaData),
    .loadStb(strobe.load), .frameDone(frameDone),
    .txData(txData), .txEn(txEn), .irqEn(irqEn),
    .portLevel(portLevel), .portDrive(portDrive), .divisor(divisor),
    .emptyFlag(emptyFlag), .endFlag(endFlag), .txReq(txReq)
  );

  serial_tx_ctrl #(
    .DATA_W(DATA_W), .DIV_W(DIV_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .txEn(txEn), .emptyFlag(emptyFlag), .divisor(divisor),
    .strobe(strobe), .frameDone(frameDone)
  );

  serial_tx_shift #(
    .DATA_W(DATA_W)
  ) u_shift (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .txData(txData), .txEn(txEn),
    .portLevel(portLevel), .portDrive(portDrive),
    .txPin(txPin), .txOe(txOe)
  );

endmodule

// File: tb/serial_tx_break_tb.sv
module serial_tx_break_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [2:0] busAddr = 3'd0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic       dmaWr = 1'b0;
  logic [7:0] dmaData = 8'd0;
  logic       txPin;
  logic       txOe;
  logic       txReq;

  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;
  int curP = 4;
  bit monEn = 1'b0;
  bit finished = 1'b0;
  logic [7:0] rxQ[$];
  int rxStartQ[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_tx_break u_dut (
    .clk(clk), .rstN(rstN),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .dmaWr(dmaWr), .dmaData(dmaData),
    .txPin(txPin), .txOe(txOe), .txReq(txReq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // all bus tasks start and end on a falling edge
  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic dmaPush(input logic [7:0] d);
    dmaData = d; dmaWr = 1'b1;
    @(negedge clk);
    dmaWr = 1'b0;
  endtask

  function automatic logic [7:0] statusExp(input bit endF, input bit emptyF);
    return {6'd0, endF, emptyF};
  endfunction

  // line monitor: decodes frames at bit centres, using the bench's own divisor copy
  initial begin
    int p;
    logic [7:0] b;
    forever begin
      @(negedge clk);
      if (monEn && txOe && txPin == 1'b0) begin
        rxStartQ.push_back(cyc);
        p = curP;
        repeat (p / 2) @(negedge clk);
        check(txPin == 1'b0, "R1 start bit", int'(txPin), 0);
        for (int i = 0; i < 8; i++) begin
          repeat (p) @(negedge clk);
          b[i] = txPin;
        end
        repeat (p) @(negedge clk);
        check(txPin == 1'b1, "R1 stop bit", int'(txPin), 1);
        rxQ.push_back(b);
      end
    end
  end

  task automatic waitEnd();
    logic [7:0] s;
    int n = 0;
    do begin
      busRead(3'd1, s);
      n++;
    end while (!s[1] && n < 400);
    check(s[1] == 1'b1, "R7 done flag reached", int'(s[1]), 1);
  endtask

  // hand one byte over by software or DMA and check the flag sequence around it
  task automatic sendByte(input logic [7:0] d, input bit useDma);
    logic [7:0] s;
    if (useDma) begin
      dmaPush(d);
    end else begin
      busWrite(3'd0, d);
      busRead(3'd1, s);
      check(s == statusExp(s[1], 1'b1), "R4 empty before handover", s, statusExp(s[1], 1'b1));
      busWrite(3'd1, 8'hFE);
    end
    check(txReq == 1'b0, "R8 request low while byte pending", txReq, 0);
    busRead(3'd1, s);
    check(s == statusExp(0, 0), useDma ? "R6 dma cleared flags" : "R4 armed clear cleared flags",
          s, statusExp(0, 0));
    busRead(3'd1, s);
    check(s == statusExp(0, 1), "R4 empty set after move to shifter", s, statusExp(0, 1));
  endtask

  initial begin
    logic [7:0] s;
    logic [7:0] d0;
    logic [7:0] d1;
    int nBefore;
    void'($urandom(32'h5EED1234));

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    busRead(3'd1, s);
    check(s == statusExp(1, 1), "R10 status after reset", s, 8'h03);
    busRead(3'd4, s);
    check(s == 8'd3, "R10 divisor reset", s, 3);
    busRead(3'd2, s);
    check(s == 8'd0, "R10 control reset", s, 0);
    check(txOe == 1'b0 && txPin == 1'b1, "R2 released pin after reset", {txOe, txPin}, 2'b01);
    check(txReq == 1'b0, "R8 request off with enable bit clear", txReq, 0);

    // register readback
    busWrite(3'd0, 8'hA5);
    busRead(3'd0, s);
    check(s == 8'hA5, "R10 data readback", s, 8'hA5);
    busWrite(3'd4, 8'd5);
    busRead(3'd4, s);
    check(s == 8'd5, "R10 divisor readback", s, 5);
    busWrite(3'd3, 8'h03);
    busRead(3'd3, s);
    check(s == 8'h03, "R10 port readback", s, 3);

    // port drives pin while disabled
    check(txOe == 1'b1 && txPin == 1'b1, "R2 port drive high", {txOe, txPin}, 2'b11);
    busWrite(3'd3, 8'h02);
    check(txOe == 1'b1 && txPin == 1'b0, "R2 port drive low", {txOe, txPin}, 2'b10);
    busWrite(3'd3, 8'h00);
    check(txOe == 1'b0 && txPin == 1'b1, "R2 port released", {txOe, txPin}, 2'b01);

    // enable with request bit; port low drive must not reach the pin
    busWrite(3'd3, 8'h02);
    busWrite(3'd4, 8'd3);
    curP = 4;
    busWrite(3'd2, 8'h03);
    busRead(3'd2, s);
    check(s == 8'h03, "R10 control readback", s, 3);
    check(txOe == 1'b1 && txPin == 1'b1, "R3 shifter owns idle pin", {txOe, txPin}, 2'b11);
    check(txReq == 1'b1, "R8 request with empty and enable", txReq, 1);
    busWrite(3'd3, 8'h00);
    monEn = 1'b1;

    // unarmed clear is ignored
    busWrite(3'd0, 8'h3C);
    busWrite(3'd1, 8'hFE);
    repeat (12 * curP) @(negedge clk);
    check(rxQ.size() == 0, "R5 no frame from unarmed clear", rxQ.size(), 0);
    check(txPin == 1'b1, "R5 line idle", txPin, 1);
    busRead(3'd1, s);
    check(s == statusExp(1, 1), "R5 flags unchanged", s, 8'h03);

    // directed corner bytes then random bytes, mixed handover paths and divisors
    for (int k = 0; k < 24; k++) begin
      if (k < 4) begin
        d0 = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'h01 : 8'h80;
      end else begin
        d0 = 8'($urandom);
      end
      if (k % 4 == 0) begin
        curP = 2 + int'($urandom % 5);
        busWrite(3'd4, 8'(curP - 1));
      end
      nBefore = rxQ.size();
      sendByte(d0, (k % 3) == 1);
      waitEnd();
      check(rxQ.size() == nBefore + 1, "R1 one frame per byte", rxQ.size(), nBefore + 1);
      if (rxQ.size() > 0) begin
        check(rxQ[rxQ.size() - 1] == d0, "R1 decoded byte lsb first", rxQ[rxQ.size() - 1], d0);
      end
      check(txPin == 1'b1, "R3 line at mark after frame", txPin, 1);
    end

    // back-to-back frames: second byte queued while first is on the line
    curP = 3;
    busWrite(3'd4, 8'd2);
    nBefore = rxQ.size();
    d0 = 8'h96;
    d1 = 8'h4B;
    sendByte(d0, 1'b0);
    busWrite(3'd0, d1);
    busRead(3'd1, s);
    check(s == statusExp(0, 1), "R7 done stays low during frame", s, statusExp(0, 1));
    busWrite(3'd1, 8'hFE);
    waitEnd();
    check(rxQ.size() == nBefore + 2, "R7 two frames sent", rxQ.size(), nBefore + 2);
    if (rxQ.size() == nBefore + 2) begin
      check(rxQ[nBefore] == d0, "R7 first byte", rxQ[nBefore], d0);
      check(rxQ[nBefore + 1] == d1, "R7 second byte", rxQ[nBefore + 1], d1);
      check(rxStartQ[nBefore + 1] - rxStartQ[nBefore] == 10 * curP, "R7 no gap between frames",
            rxStartQ[nBefore + 1] - rxStartQ[nBefore], 10 * curP);
    end

    // request enable bit off
    busWrite(3'd2, 8'h01);
    check(txReq == 1'b0, "R8 request masked", txReq, 0);

    // break: port low drive takes effect once enable clears
    monEn = 1'b0;
    busWrite(3'd3, 8'h02);
    check(txPin == 1'b1, "R3 port ignored while enabled", txPin, 1);
    busWrite(3'd2, 8'h00);
    for (int i = 0; i < 20; i++) begin
      check(txPin == 1'b0 && txOe == 1'b1, "R9 break held low", {txOe, txPin}, 2'b10);
      @(negedge clk);
    end
    busRead(3'd1, s);
    check(s == statusExp(1, 1), "R10 flags set while disabled", s, 8'h03);
    busWrite(3'd3, 8'h03);
    check(txPin == 1'b1, "R9 break released", txPin, 1);

    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected finish at cycle %0d", cyc);
    summary();
  end

endmodule